// File: doc/BRIEF.md
# E1 Transmit Alarm Insertion Unit

This block sits in the transmit path of a 2048 kbit/s E1 framer, one bit position before the line coder. On each bit-period enable it takes one serial bit together with its position in the frame (a bit count from 0 to 255) and the frame number inside the 16-frame CRC-4 multiframe. It returns one registered transmit bit. That bit is either the incoming bit or all ones, with the all-ones override applied to the whole frame, to timeslot 0 only, or to timeslot 16 only. In the two E-bit positions it returns the far-end CRC-4 comparison results, or a forced level when CRC-4 sync has been lost.

The same stage turns the receive alarm status into output enables for the serial data stream and for the signalling stream. While the block's enable bit for a stream is set, an alarm tristates that stream. The stage also divides the bit-period enable into an 8 kHz frame pulse or a 64 kHz clock for the frame-pulse pin. All control inputs are static bits from a control word. The receive framer, CRC-4 generation and line coding are outside the block, and their results arrive as inputs.

Top module: `e1_tx_alarm_ins`

## Requirements
- R1: While ctl_all_ais is 1, every bit that tx_out registers is 1, at every bit count and in every frame.
- R2: With all overrides clear, tx_out registers tx_in at every position that is not an E-bit position.
- R3: While ctl_ts0_ais is 1, tx_out is 1 for bit counts 0 to 7 (timeslot 0). Timeslot 0 is the only timeslot it affects.
- R4: While ctl_ts16_ais is 1, tx_out is 1 for bit counts 128 to 135 (timeslot 16). Timeslot 16 is the only timeslot it affects.
- R5: An E-bit position is bit count 0 in multiframe frame 13 or frame 15. With crc_lost at 0, frame 13 sends rx_cmp[0] and frame 15 sends rx_cmp[1]. Bit count 0 of any other frame passes tx_in.
- R6: With crc_lost at 1, both E-bit positions send the value of ctl_ebit_force (0 gives zeros, 1 gives ones).
- R7: The overrides have a fixed order of priority: ctl_all_ais first, then ctl_ts0_ais and ctl_ts16_ais, then E-bit insertion, then tx_in.
- R8: One clock after its inputs, data_oe is 0 when ctl_data_tri is 1 and any of los, lof, crc_lost or ais_rx is 1. Otherwise data_oe is 1.
- R9: One clock after its inputs, sig_oe is 0 when ctl_sig_tri is 1 and either mf_lost or ais16_rx is 1. Otherwise sig_oe is 1.
- R10: A divider counts bit enables from 0 after reset, modulo 256. fp_out is 1 only at count 0 when ctl_clk64 is 0. When ctl_clk64 is 1, fp_out is 1 for counts 0 to 15 of each 32-count period (64 kHz).
- R11: tx_out and the divider advance only on clock edges where bit_en is 1. Otherwise both hold their values.
- R12: During reset, tx_out is 0, data_oe and sig_oe are 0, and the divider is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per 2048 kHz bit period |
| tx_in | input | 1 | Serial transmit bit |
| bit_cnt | input | 8 | Bit position in the frame, 0 to 255 |
| mf_frame | input | 4 | Frame number in the CRC-4 multiframe |
| rx_cmp | input | 2 | Received CRC-4 results: [0] for frame 13, [1] for frame 15 |
| crc_lost | input | 1 | CRC-4 multiframe sync lost |
| los | input | 1 | Loss of signal |
| lof | input | 1 | Basic frame sync lost |
| ais_rx | input | 1 | AIS received |
| mf_lost | input | 1 | Signalling multiframe sync lost |
| ais16_rx | input | 1 | AIS received in timeslot 16 |
| ctl_all_ais | input | 1 | Send all ones in the whole frame |
| ctl_ts0_ais | input | 1 | Send all ones in timeslot 0 |
| ctl_ts16_ais | input | 1 | Send all ones in timeslot 16 |
| ctl_ebit_force | input | 1 | E-bit level while CRC-4 sync is lost |
| ctl_data_tri | input | 1 | Let alarms tristate the data stream |
| ctl_sig_tri | input | 1 | Let alarms tristate the signalling stream |
| ctl_clk64 | input | 1 | fp_out carries 64 kHz (1) or 8 kHz (0) |
| tx_out | output | 1 | Registered transmit bit |
| data_oe | output | 1 | Data stream output enable |
| sig_oe | output | 1 | Signalling stream output enable |
| fp_out | output | 1 | Frame pulse or 64 kHz clock |

## Verification
The bench sweeps every bit count in frames 12 to 15 under all 32 combinations of the three AIS bits, the E-bit force and the CRC-4 sync state. A timeslot window that is off by one bit would show up at counts 7/8 or 135/136. An E-bit placed in the wrong frame, or with the rx_cmp bits swapped, would show up in frame 12 or 14, or in a wrong value in frame 13 or 15. A wrong priority order would let an E-bit or a zero escape under AIS. A separate sweep covers every alarm and enable combination for both output enables, which catches a missing or cross-wired alarm term. Idle cycles with bit_en low change tx_in, to show that a design advancing the output register or the divider without the enable would drift. The divider is checked against a count kept in the bench in both pulse modes.

// File: rtl/e1ta_pkg.sv
package e1ta_pkg;
  localparam int TS_BITS    = 8;
  localparam int N_TS       = 32;
  localparam int FRAME_BITS = TS_BITS * N_TS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TS_W       = $clog2(N_TS);
  localparam int MF_W       = 4;
  localparam int DIV64      = 32;
endpackage

// File: rtl/e1ta_rst_sync.sv
module e1ta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/e1ta_ebit.sv
module e1ta_ebit #(
  parameter int BIT_W  = 8,
  parameter int MF_W   = 4,
  parameter int EFRM_A = 13,
  parameter int EFRM_B = 15
) (
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic [MF_W-1:0]  mf_frame,
  input  logic [1:0]       rx_cmp,
  input  logic             crc_lost,
  input  logic             force_lvl,
  output logic             is_ebit,
  output logic             ebit_val
);
  localparam logic [MF_W-1:0] FA = MF_W'(EFRM_A);
  localparam logic [MF_W-1:0] FB = MF_W'(EFRM_B);

  logic in_a, in_b;

  always_comb begin
    in_a     = (mf_frame == FA);
    in_b     = (mf_frame == FB);
    is_ebit  = (bit_cnt == '0) && (in_a || in_b);
    if (crc_lost) ebit_val = force_lvl;
    else          ebit_val = in_b ? rx_cmp[1] : rx_cmp[0];
  end
endmodule

// File: rtl/e1ta_overlay.sv
module e1ta_overlay
  import e1ta_pkg::*;
#(
  parameter int TS_ZERO = 0,
  parameter int TS_SIG  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             din,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic             all_ais,
  input  logic             ts0_ais,
  input  logic             ts16_ais,
  input  logic             is_ebit,
  input  logic             ebit_val,
  output logic             tx_out
);
  localparam int SH = $clog2(TS_BITS);
  localparam logic [TS_W-1:0] TS0_IDX  = TS_W'(TS_ZERO);
  localparam logic [TS_W-1:0] TS16_IDX = TS_W'(TS_SIG);

  logic [TS_W-1:0] ts_idx;
  logic hit0, hit16, tx_nxt, tx_q;

  always_comb begin
    ts_idx = TS_W'(bit_cnt >> SH);
    hit0   = (ts_idx == TS0_IDX);
    hit16  = (ts_idx == TS16_IDX);
    tx_nxt = din;
    if (is_ebit)           tx_nxt = ebit_val;
    if (hit16 && ts16_ais) tx_nxt = 1'b1;
    if (hit0 && ts0_ais)   tx_nxt = 1'b1;
    if (all_ais)           tx_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_q <= 1'b0;
    else if (bit_en) tx_q <= tx_nxt;
  end

  assign tx_out = tx_q;

  a_r1_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && all_ais) |=> tx_out);
  a_r3_ts0_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ts0_ais && bit_cnt < BIT_W'(TS_BITS)) |=> tx_out);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_out));
endmodule

// File: rtl/e1ta_oe.sv
module e1ta_oe (
  input  logic clk,
  input  logic rst_n,
  input  logic los,
  input  logic lof,
  input  logic crc_lost,
  input  logic ais_rx,
  input  logic mf_lost,
  input  logic ais16_rx,
  input  logic data_tri,
  input  logic sig_tri,
  output logic data_oe,
  output logic sig_oe
);
  logic d_nxt, s_nxt, d_q, s_q;

  always_comb begin
    d_nxt = !(data_tri && (los || lof || crc_lost || ais_rx));
    s_nxt = !(sig_tri && (mf_lost || ais16_rx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      d_q <= d_nxt;
      s_q <= s_nxt;
    end
  end

  assign data_oe = d_q;
  assign sig_oe  = s_q;

  a_r8_los_tristates: assert property (@(posedge clk) disable iff (!rst_n)
    (data_tri && los) |=> !data_oe);
  a_r8_driven_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !data_tri |=> data_oe);
  a_r9_sig_driven_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_tri |=> sig_oe);
endmodule

// File: rtl/e1ta_fpdiv.sv
module e1ta_fpdiv
  import e1ta_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sel64,
  output logic fp_out
);
  localparam int HB = $clog2(DIV64) - 1;

  logic [BIT_W-1:0] div_q, div_nxt;

  always_comb div_nxt = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (bit_en) div_q <= div_nxt;
  end

  assign fp_out = sel64 ? !div_q[HB] : (div_q == '0);

  a_r10_div_step: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (div_q == $past(div_q) + 1'b1));
  a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(div_q));
endmodule

// File: rtl/e1_tx_alarm_ins.sv
module e1_tx_alarm_ins
  import e1ta_pkg::*;
#(
  parameter int EFRM_A = 13,
  parameter int EFRM_B = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             tx_in,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic [MF_W-1:0]  mf_frame,
  input  logic [1:0]       rx_cmp,
  input  logic             crc_lost,
  input  logic             los,
  input  logic             lof,
  input  logic             ais_rx,
  input  logic             mf_lost,
  input  logic             ais16_rx,
  input  logic             ctl_all_ais,
  input  logic             ctl_ts0_ais,
  input  logic             ctl_ts16_ais,
  input  logic             ctl_ebit_force,
  input  logic             ctl_data_tri,
  input  logic             ctl_sig_tri,
  input  logic             ctl_clk64,
  output logic             tx_out,
  output logic             data_oe,
  output logic             sig_oe,
  output logic             fp_out
);
  logic rst_q_n, is_ebit, ebit_val;

  e1ta_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  e1ta_ebit #(.BIT_W(BIT_W), .MF_W(MF_W), .EFRM_A(EFRM_A), .EFRM_B(EFRM_B)) u_ebit (
    .bit_cnt(bit_cnt), .mf_frame(mf_frame), .rx_cmp(rx_cmp),
    .crc_lost(crc_lost), .force_lvl(ctl_ebit_force),
    .is_ebit(is_ebit), .ebit_val(ebit_val));

  e1ta_overlay u_ovl (
    .clk(clk), .rst_n(rst_q_n), .bit_en(bit_en), .din(tx_in), .bit_cnt(bit_cnt),
    .all_ais(ctl_all_ais), .ts0_ais(ctl_ts0_ais), .ts16_ais(ctl_ts16_ais),
    .is_ebit(is_ebit), .ebit_val(ebit_val), .tx_out(tx_out));

  e1ta_oe u_oe (
    .clk(clk), .rst_n(rst_q_n), .los(los), .lof(lof), .crc_lost(crc_lost),
    .ais_rx(ais_rx), .mf_lost(mf_lost), .ais16_rx(ais16_rx),
    .data_tri(ctl_data_tri), .sig_tri(ctl_sig_tri),
    .data_oe(data_oe), .sig_oe(sig_oe));

  e1ta_fpdiv u_div (
    .clk(clk), .rst_n(rst_q_n), .bit_en(bit_en), .sel64(ctl_clk64), .fp_out(fp_out));
endmodule

// File: tb/e1_tx_alarm_ins_tb_top.sv
`timescale 1ns/1ps
module e1_tx_alarm_ins_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_en, tx_in, crc_lost, los, lof, ais_rx, mf_lost, ais16_rx;
  logic [7:0] bit_cnt;
  logic [3:0] mf_frame;
  logic [1:0] rx_cmp;
  logic c_all, c_t0, c_t16, c_frc, c_dtri, c_stri, c_64;
  logic tx_out, data_oe, sig_oe, fp_out;

  int checks = 0, errors = 0, div_m = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  e1_tx_alarm_ins dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_in(tx_in), .bit_cnt(bit_cnt),
    .mf_frame(mf_frame), .rx_cmp(rx_cmp), .crc_lost(crc_lost), .los(los), .lof(lof),
    .ais_rx(ais_rx), .mf_lost(mf_lost), .ais16_rx(ais16_rx),
    .ctl_all_ais(c_all), .ctl_ts0_ais(c_t0), .ctl_ts16_ais(c_t16),
    .ctl_ebit_force(c_frc), .ctl_data_tri(c_dtri), .ctl_sig_tri(c_stri),
    .ctl_clk64(c_64), .tx_out(tx_out), .data_oe(data_oe), .sig_oe(sig_oe),
    .fp_out(fp_out));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx(input logic d, input int b, input int f);
    if (c_all) return 1'b1;
    if (c_t0 && b < 8) return 1'b1;
    if (c_t16 && b >= 128 && b < 136) return 1'b1;
    if (b == 0 && (f == 13 || f == 15))
      return crc_lost ? c_frc : ((f == 15) ? rx_cmp[1] : rx_cmp[0]);
    return d;
  endfunction

  function automatic logic exp_fp();
    if (c_64) return ((div_m % 32) < 16);
    return ((div_m % 256) == 0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; bit_en = 0; tx_in = 0; bit_cnt = 0; mf_frame = 0; rx_cmp = 0;
    crc_lost = 0; los = 0; lof = 0; ais_rx = 0; mf_lost = 0; ais16_rx = 0;
    c_all = 0; c_t0 = 0; c_t16 = 0; c_frc = 0; c_dtri = 0; c_stri = 0; c_64 = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 tx_out", tx_out, 1'b0);
    chk("R12 data_oe", data_oe, 1'b0);
    chk("R12 sig_oe", sig_oe, 1'b0);
    chk("R12 fp_out", fp_out, 1'b1);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R8 R9 sweep over every alarm and enable combination
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      {c_stri, c_dtri, ais16_rx, mf_lost, ais_rx, lof, los, crc_lost} = v[7:0];
      @(posedge clk); #1;
      chk("R8 data_oe", data_oe, !(c_dtri && (los || lof || crc_lost || ais_rx)));
      chk("R9 sig_oe", sig_oe, !(c_stri && (mf_lost || ais16_rx)));
      chk("R11 tx_out held with bit_en low", tx_out, 1'b0);
    end
    @(negedge clk);
    {c_stri, c_dtri, ais16_rx, mf_lost, ais_rx, lof, los, crc_lost} = '0;

    // R1..R7 R10 sweep
    for (int c = 0; c < 32; c++) begin
      for (int f = 12; f < 16; f++) begin
        for (int b = 0; b < 256; b++) begin
          logic e;
          @(negedge clk);
          {crc_lost, c_frc, c_t16, c_t0, c_all} = c[4:0];
          rx_cmp   = 2'(c + f);
          c_64     = c[0] ^ c[2];
          bit_en   = 1;
          bit_cnt  = 8'(b);
          mf_frame = 4'(f);
          tx_in    = 1'(((b * 37 + f * 11 + c) >> 2) & 1);
          e = exp_tx(tx_in, b, f);
          @(posedge clk); #1;
          div_m++;
          if (c_all)                             chk("R1 whole-frame ones", tx_out, e);
          else if (c_t0 && b < 8)                chk("R3/R7 timeslot0 ones", tx_out, e);
          else if (c_t16 && b >= 128 && b < 136) chk("R4 timeslot16 ones", tx_out, e);
          else if (b == 0 && (f == 13 || f == 15)) begin
            if (crc_lost) chk("R6 forced E-bit", tx_out, e);
            else          chk("R5 E-bit result", tx_out, e);
          end else                               chk("R2 pass-through", tx_out, e);
          chk("R10 fp_out", fp_out, exp_fp());
        end
      end
    end

    // R11 idle cycles: output and divider hold
    @(negedge clk);
    c_all = 0; c_t0 = 0; c_t16 = 0; crc_lost = 0;
    bit_cnt = 8'd50; mf_frame = 4'd3; tx_in = 1'b1; bit_en = 1;
    @(posedge clk); #1; div_m++;
    chk("R2 pass one", tx_out, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bit_en = 0; tx_in = 1'(k & 1) ^ 1'b1; tx_in = 1'b0; c_64 = 1'(k & 1);
      @(posedge clk); #1;
      chk("R11 tx_out hold", tx_out, 1'b1);
      chk("R11 fp_out hold", fp_out, exp_fp());
    end
    @(negedge clk); bit_en = 1;
    @(posedge clk); #1; div_m++;
    chk("R11 resumes", tx_out, 1'b0);
    chk("R10 fp_out resume", fp_out, exp_fp());
    finish_run();
  end
endmodule